// File: doc/BRIEF.md
# Interrupt Status and Enable Register

This block is a 16-bit interrupt control and status word for a PHY management unit. The low byte holds eight sticky event flags. Each flag is set by a one-cycle event pulse, except the receive-error flag, which is set on a rising edge of a level signal. The high byte holds one enable per flag. The management side reads the whole word through a read strobe. That read returns the flags as they were before the read, and clears all of them at the end of the read cycle. A write strobe loads only the enable byte.

The block drives one interrupt output. The output is in its asserted level whenever some flag and its matching enable are both 1. A polarity input, which comes from another register, selects whether the asserted level is high or low.

The receive-error edge detector is a two-state machine, `rxe_state_t`, with these states:
- `RXE_LOW`: the level was last sampled low.
- `RXE_HIGH`: the level was last sampled high.

It has two transitions:
- RISE (`RXE_LOW` to `RXE_HIGH`): taken when the level is high in `RXE_LOW`. The cycle that takes it raises the flag-set request.
- FALL (`RXE_HIGH` to `RXE_LOW`): taken when the level is low in `RXE_HIGH`.

Top module: `irq_stat_reg`

## Requirements
- R1: Flag bit i of `rd_data` (jabber=7, receive error=6, page received=5, parallel-detect fault=4, partner acknowledge=3, link change=2, remote fault=1, auto-negotiation complete=0) becomes 1 at the clock edge that samples `evt_pulse[i]` high. It stays 1 until a read clears it.
- R2: A clock edge that samples `rd_stb` high clears every flag. During that cycle, `rd_data` shows the flag values from before the clear.
- R3: A clock edge that samples `wr_stb` high loads `wr_data[15:8]` into the enable byte (`rd_data[15:8]`, where enable bit i+8 belongs to flag i). `wr_data[7:0]` is ignored and never changes a flag.
- R4: The interrupt is asserted exactly when some flag bit i and enable bit i+8 are both 1. It follows the register contents in the same cycle.
- R5: With `pol_hi`=1, the asserted level of `irq_out` is 1 and the idle level is 0. With `pol_hi`=0, both levels are inverted. A change of `pol_hi` takes effect at once.
- R6: Flag 6 is set only when `rx_err_lvl` is sampled high after having been sampled low (or after reset). A level held high sets it only once, and `evt_pulse[6]` has no effect.
- R7: An event sampled at the same edge as a clearing read leaves its flag set after that edge.
- R8: Reset (`rst_n` low, asynchronous) sets all flags and enables to 0 and puts the edge detector in `RXE_LOW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Read strobe; the clock edge that samples it clears all flags |
| wr_stb | input | 1 | Write strobe; loads the enable byte |
| wr_data | input | 16 | Write data; only bits 15:8 are used |
| evt_pulse | input | 8 | One-cycle event pulses, one per flag (bit 6 unused) |
| rx_err_lvl | input | 1 | Receive-error level; its rising edge sets flag 6 |
| pol_hi | input | 1 | Interrupt polarity: 1 selects an active-high output |
| rd_data | output | 16 | Register word: enables in 15:8, flags in 7:0 |
| irq_out | output | 1 | Interrupt output at the level chosen by `pol_hi` |

## Verification
`rd_data` and `irq_out` are combinational from the stored word and `pol_hi`, so a polarity change shows up in the same cycle. Every pulse, edge, write or read shows up after exactly one rising edge. The bench drives each stimulus at a falling edge and samples 5 ns later. At that point it sees the state built by all earlier rising edges and the pre-clear value of a read in progress. The effect of the current stimulus is checked in the next table row. Reset is checked the same way, 5 ns after `rst_n` falls, with no rising edge in between.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int unsigned IRQ_NFLAG   = 8;
    localparam int unsigned IRQ_RXE_IDX = 6;

    typedef enum logic {
        RXE_LOW  = 1'b0,
        RXE_HIGH = 1'b1
    } rxe_state_t;

endpackage

// File: rtl/irq_rxe_edge.sv
module irq_rxe_edge
    import irq_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);

    rxe_state_t state_q;
    rxe_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RXE_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RXE_LOW:  if (lvl)  state_d = RXE_HIGH;
            RXE_HIGH: if (!lvl) state_d = RXE_LOW;
            default:  state_d = RXE_LOW;
        endcase
    end

    always_comb begin
        rise = 1'b0;
        unique case (state_q)
            RXE_LOW:  rise = lvl;
            RXE_HIGH: rise = 1'b0;
            default:  rise = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned NFLAG   = 8,
    parameter int unsigned RXE_IDX = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] evt_pulse,
    input  logic             rxe_rise,
    input  logic             clr,
    output logic [NFLAG-1:0] flags_q
);

    logic [NFLAG-1:0] set_v;
    logic             unused_rxe_pulse;

    assign unused_rxe_pulse = evt_pulse[RXE_IDX];

    for (genvar i = 0; i < NFLAG; i++) begin : g_set
        if (i == RXE_IDX) begin : g_edge
            assign set_v[i] = rxe_rise;
        end else begin : g_pulse
            assign set_v[i] = evt_pulse[i];
        end
    end

    // Set wins over a clear at the same edge, so no event is lost.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~{NFLAG{clr}}) | set_v;
        end
    end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int unsigned NFLAG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [NFLAG-1:0] wr_bits,
    output logic [NFLAG-1:0] en_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_stb) begin
            en_q <= wr_bits;
        end
    end

endmodule

// File: rtl/irq_drive.sv
module irq_drive #(
    parameter int unsigned NFLAG = 8
) (
    input  logic [NFLAG-1:0] flags,
    input  logic [NFLAG-1:0] en,
    input  logic             pol_hi,
    output logic             irq
);

    logic hit;

    always_comb begin
        hit = |(flags & en);
        irq = pol_hi ? hit : ~hit;
    end

endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
    import irq_stat_pkg::*;
#(
    parameter int unsigned NFLAG   = IRQ_NFLAG,
    parameter int unsigned RXE_IDX = IRQ_RXE_IDX
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_stb,
    input  logic               wr_stb,
    input  logic [2*NFLAG-1:0] wr_data,
    input  logic [NFLAG-1:0]   evt_pulse,
    input  logic               rx_err_lvl,
    input  logic               pol_hi,
    output logic [2*NFLAG-1:0] rd_data,
    output logic               irq_out
);

    localparam int unsigned WORD = 2 * NFLAG;

    logic             rxe_rise;
    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] en_q;
    logic             unused_wr_low;

    assign unused_wr_low = ^wr_data[NFLAG-1:0];

    irq_rxe_edge u_rxe (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (rx_err_lvl),
        .rise  (rxe_rise)
    );

    irq_flag_bank #(.NFLAG(NFLAG), .RXE_IDX(RXE_IDX)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .rxe_rise  (rxe_rise),
        .clr       (rd_stb),
        .flags_q   (flags_q)
    );

    irq_enable_reg #(.NFLAG(NFLAG)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_bits (wr_data[WORD-1:NFLAG]),
        .en_q    (en_q)
    );

    irq_drive #(.NFLAG(NFLAG)) u_drive (
        .flags  (flags_q),
        .en     (en_q),
        .pol_hi (pol_hi),
        .irq    (irq_out)
    );

    assign rd_data = {en_q, flags_q};

endmodule

// File: rtl/irq_stat_chk.sv
module irq_stat_chk #(
    parameter int unsigned NFLAG   = 8,
    parameter int unsigned RXE_IDX = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_stb,
    input logic               wr_stb,
    input logic [2*NFLAG-1:0] wr_data,
    input logic [NFLAG-1:0]   evt_pulse,
    input logic               rx_err_lvl,
    input logic               pol_hi,
    input logic [2*NFLAG-1:0] rd_data,
    input logic               irq_out
);

    logic [NFLAG-1:0] fl;
    logic [NFLAG-1:0] en;
    logic             rx_prev;

    assign fl = rd_data[NFLAG-1:0];
    assign en = rd_data[2*NFLAG-1:NFLAG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_prev <= 1'b0;
        else        rx_prev <= rx_err_lvl;
    end

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((fl & $past(fl)) == $past(fl))); // R1

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && evt_pulse == '0 && !rx_err_lvl) |=> (fl == '0)); // R2

    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (en == $past(wr_data[2*NFLAG-1:NFLAG]))); // R3

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(en)); // R3

    AST_IRQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fl & en)) |-> (irq_out == pol_hi)); // R4

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(fl & en)) |-> (irq_out != pol_hi)); // R5

    AST_RXE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rx_err_lvl && rx_prev) |=> !fl[RXE_IDX]); // R6

    AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && evt_pulse[0]) |=> fl[0]); // R7

endmodule

bind irq_stat_reg irq_stat_chk #(.NFLAG(NFLAG), .RXE_IDX(RXE_IDX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .evt_pulse  (evt_pulse),
    .rx_err_lvl (rx_err_lvl),
    .pol_hi     (pol_hi),
    .rd_data    (rd_data),
    .irq_out    (irq_out)
);

// File: tb/tb_irq_stat_reg.sv
module tb_irq_stat_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  evt_pulse = '0;
    logic        rx_err_lvl = 1'b0;
    logic        pol_hi = 1'b1;
    logic [15:0] rd_data;
    logic        irq_out;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    irq_stat_reg dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .evt_pulse  (evt_pulse),
        .rx_err_lvl (rx_err_lvl),
        .pol_hi     (pol_hi),
        .rd_data    (rd_data),
        .irq_out    (irq_out)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [7:0]  evt;
        logic        rxe;
        logic        wr;
        logic [15:0] wdata;
        logic        rd;
        logic        pol;
        logic [15:0] exp_rd;
        logic        exp_irq;
    } vec_t;

    // Each row: inputs driven this cycle; expected outputs seen before its rising edge.
    localparam int NVEC = 24;
    localparam vec_t VEC [NVEC] = '{
        '{8'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b0}, // 0  idle
        '{8'h01, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b0}, // 1  R1 pulse flag 0
        '{8'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0001, 1'b0}, // 2  R1 set, R4 masked
        '{8'h00, 1'b0, 1'b1, 16'h01FF, 1'b0, 1'b1, 16'h0001, 1'b0}, // 3  R3 write, low ignored
        '{8'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0101, 1'b1}, // 4  R4 unmasked
        '{8'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0101, 1'b0}, // 5  R5 active low
        '{8'h00, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0101, 1'b1}, // 6  R2 read pre-clear
        '{8'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0100, 1'b0}, // 7  R2 cleared
        '{8'h00, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0100, 1'b0}, // 8  R6 rx rises
        '{8'h00, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0140, 1'b0}, // 9  R6 flag set
        '{8'h00, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0140, 1'b0}, // 10 R6 read, rx held
        '{8'h00, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0100, 1'b0}, // 11 R6 no re-set
        '{8'h40, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0100, 1'b0}, // 12 R6 pulse bit6
        '{8'h00, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0100, 1'b0}, // 13 R6 pulse ignored
        '{8'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0140, 1'b0}, // 14 R6 second rise
        '{8'h80, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0140, 1'b0}, // 15 R7 event+read
        '{8'h00, 1'b0, 1'b1, 16'h8000, 1'b0, 1'b1, 16'h0180, 1'b0}, // 16 R7 kept
        '{8'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h8080, 1'b1}, // 17 R4 jabber
        '{8'h3F, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h8080, 1'b1}, // 18 R1 many pulses
        '{8'h00, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h80BF, 1'b1}, // 19 R2 read all
        '{8'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h8000, 1'b0}, // 20 R2 cleared
        '{8'h0C, 1'b0, 1'b1, 16'h00AA, 1'b0, 1'b1, 16'h8000, 1'b0}, // 21 R3 clear enables
        '{8'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h000C, 1'b1}, // 22 R5 idle high
        '{8'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h000C, 1'b0}  // 23 R5 idle low
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 5000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<5000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic idle();
        evt_pulse = '0; rd_stb = 1'b0; wr_stb = 1'b0; wr_data = '0;
    endtask

    initial begin
        // R8 reset state
        #5;
        chk("R8 reset word", rd_data, 16'h0000);
        chk("R8 reset irq", {15'd0, irq_out}, 16'h0000);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            evt_pulse  = VEC[i].evt;
            rx_err_lvl = VEC[i].rxe;
            wr_stb     = VEC[i].wr;
            wr_data    = VEC[i].wdata;
            rd_stb     = VEC[i].rd;
            pol_hi     = VEC[i].pol;
            #5;
            chk($sformatf("vec%0d word", i), rd_data, VEC[i].exp_rd);
            chk($sformatf("vec%0d irq", i), {15'd0, irq_out}, {15'd0, VEC[i].exp_irq});
        end

        // R2/R3: read and write in the same cycle
        @(negedge clk); idle(); evt_pulse = 8'h20;
        @(negedge clk); idle(); #5;
        chk("R1 page flag", rd_data, 16'h002C);
        @(negedge clk); rd_stb = 1'b1; wr_stb = 1'b1; wr_data = 16'h20FF; #5;
        chk("R2 pre-clear with write", rd_data, 16'h002C);
        @(negedge clk); idle(); #5;
        chk("R2 R3 read+write", rd_data, 16'h2000);
        chk("R4 idle after clear", {15'd0, irq_out}, 16'h0000);
        @(negedge clk); evt_pulse = 8'h20;
        @(negedge clk); idle(); #5;
        chk("R4 page enabled", {15'd0, irq_out}, 16'h0001);

        // R8 mid-run reset
        @(negedge clk); rst_n = 1'b0; #5;
        chk("R8 mid reset word", rd_data, 16'h0000);
        chk("R8 mid reset irq", {15'd0, irq_out}, 16'h0000);
        @(negedge clk); rst_n = 1'b1; #5;
        chk("R8 after release", rd_data, 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule